// File: doc/BRIEF.md
# Timestamp Interrupt Generator with Count and Timeout Thresholds

This block decides when to interrupt the host about timestamps that are waiting in several per-channel queues. Each channel has a write strobe that pulses once for every timestamp written into that channel's queue. The block keeps a separate count for each channel of the timestamps stored since the last interrupt. When any single channel's count goes above a programmable count threshold, the block raises an interrupt.

A second path measures the time since the last interrupt. It counts the pulses of an external 1 ms tick and compares that number with a programmable time threshold. This timeout raises an interrupt only if at least one timestamp has arrived since the last interrupt. The purpose is to deliver a small trickle of timestamps within a bounded time, without raising interrupts when nothing has been collected.

Either condition produces one single-cycle interrupt pulse. The same clock edge that raises the pulse clears every channel count and the millisecond timer. While the acquisition enable is low, all tracking state is held cleared and no interrupt is produced.

Top module: `ts_irq_gen`

## Requirements
- R1: While reset is active, and on the first cycles after it is released with no strobes, `irq_o` is low.
- R2: When any one channel's count of strobes since the last interrupt is strictly greater than `cnt_thresh_i`, `irq_o` goes high on the next rising edge. A strobe sampled at edge N makes `irq_o` high after edge N+1.
- R3: Counts are kept per channel and are never summed across channels. Strobes spread over several channels, none of which exceeds the threshold on its own, raise no interrupt.
- R4: When the number of ms ticks since the last interrupt has reached `time_thresh_i` and at least one strobe has been counted, `irq_o` goes high on the next rising edge.
- R5: With no strobe counted, the ms timer stops at `time_thresh_i` and no interrupt is raised. A later strobe then raises `irq_o` one edge after the count is updated.
- R6: The edge that raises `irq_o` clears all channel counts and the ms timer. A strobe sampled on that edge is counted as the first one of the new interval, and a tick sampled on that edge is dropped. No new interrupt can fire in the cycle in which `irq_o` is high.
- R7: `irq_o` is a one-cycle pulse. A count condition and a timeout condition that are true together produce one pulse only.
- R8: While `acq_en_i` is low, strobes and ticks have no effect, `irq_o` stays low, and counts from before the enable went low are discarded.
- R9: A channel count saturates at 2^CNT_W-1 and does not wrap. With `cnt_thresh_i` = 255, any number of strobes raises no count interrupt, and the count stays non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acq_en_i | input | 1 | Acquisition enable; when low, all state is held cleared |
| wr_stb_i | input | NUM_CH (5) | Per-channel timestamp write strobe, one pulse per timestamp |
| ms_tick_i | input | 1 | Single-cycle pulse once per millisecond |
| cnt_thresh_i | input | CNT_W (8) | Count threshold; an interrupt fires when a channel count exceeds it |
| time_thresh_i | input | TIME_W (32) | Timeout threshold in milliseconds |
| irq_o | output | 1 | Interrupt pulse, one cycle wide |

## Verification
The bound checker watches the following on every cycle:
- **Pulse width:** the interrupt pulse is only one cycle wide.
- **Quiet when disabled:** nothing fires while the enable is low.
- **Restart:** the counts and the timer restart on the edge that raises the pulse.
- **Firing:** a count above threshold, or a reached timeout with timestamps present, fires on the next edge.
- **Saturation:** a saturated count holds its value.

Some behaviours can only be shown by the bench's scenarios, which compare every cycle against a behavioural model:
- that channels are never summed;
- that a stalled timer fires as soon as a timestamp arrives;
- that counts gathered before a disable are lost;
- the exact number of pulses a sequence of back-to-back strobes produces.

// File: rtl/ts_irq_pkg.sv
package ts_irq_pkg;

   // Per-channel flags handed from a counter to the interrupt decision
   typedef struct packed {
      logic over;   // count strictly above threshold
      logic busy;   // at least one timestamp in this interval
   } ch_flag_t;

endpackage

// File: rtl/ts_chan_cnt.sv
module ts_chan_cnt #(
   parameter int unsigned CNT_W = 8
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 en_i,
   input  logic                 clr_i,
   input  logic                 stb_i,
   input  logic [CNT_W-1:0]     thr_i,
   output logic [CNT_W-1:0]     cnt_o,
   output ts_irq_pkg::ch_flag_t flag_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (!en_i) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         // a strobe on the restart edge opens the new interval
         cnt_q <= stb_i ? CNT_ONE : '0;
      end else if (stb_i && (cnt_q != CNT_MAX)) begin
         cnt_q <= cnt_q + CNT_ONE;
      end
   end

   assign cnt_o       = cnt_q;
   assign flag_o.over = (cnt_q > thr_i);
   assign flag_o.busy = (cnt_q != '0);

endmodule

// File: rtl/ts_ms_timer.sv
module ts_ms_timer #(
   parameter int unsigned TIME_W = 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              en_i,
   input  logic              clr_i,
   input  logic              tick_i,
   input  logic [TIME_W-1:0] thr_i,
   output logic [TIME_W-1:0] ms_o,
   output logic              due_o
);
   localparam logic [TIME_W-1:0] MS_ONE = TIME_W'(1);

   logic [TIME_W-1:0] ms_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ms_q <= '0;
      end else if (!en_i || clr_i) begin
         ms_q <= '0;
      end else if (tick_i && (ms_q < thr_i)) begin
         // stops at the threshold, so it can never wrap
         ms_q <= ms_q + MS_ONE;
      end
   end

   assign ms_o  = ms_q;
   assign due_o = (ms_q >= thr_i);

endmodule

// File: rtl/ts_irq_pulse.sv
module ts_irq_pulse #(
   parameter int unsigned NUM_CH = 5
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 en_i,
   input  ts_irq_pkg::ch_flag_t flags_i [NUM_CH],
   input  logic                 due_i,
   output logic                 fire_o,
   output logic                 irq_o
);
   logic [NUM_CH-1:0] over_v;
   logic [NUM_CH-1:0] busy_v;
   logic              any_over;
   logic              any_busy;
   logic              irq_q;

   for (genvar g = 0; g < NUM_CH; g++) begin : g_unpack
      assign over_v[g] = flags_i[g].over;
      assign busy_v[g] = flags_i[g].busy;
   end

   if (NUM_CH == 1) begin : g_single
      assign any_over = over_v[0];
      assign any_busy = busy_v[0];
   end else begin : g_multi
      assign any_over = |over_v;
      assign any_busy = |busy_v;
   end

   // no decision in the pulse cycle: keeps the pulse one cycle wide
   assign fire_o = en_i && !irq_q && (any_over || (due_i && any_busy));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         irq_q <= 1'b0;
      end else begin
         irq_q <= fire_o;
      end
   end

   assign irq_o = irq_q;

endmodule

// File: rtl/ts_irq_gen.sv
module ts_irq_gen #(
   parameter int unsigned NUM_CH = 5,
   parameter int unsigned CNT_W  = 8,
   parameter int unsigned TIME_W = 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              acq_en_i,
   input  logic [NUM_CH-1:0] wr_stb_i,
   input  logic              ms_tick_i,
   input  logic [CNT_W-1:0]  cnt_thresh_i,
   input  logic [TIME_W-1:0] time_thresh_i,
   output logic              irq_o
);
   localparam int unsigned FLAT_W = NUM_CH * CNT_W;

   initial begin
      if (NUM_CH < 1)  $error("ts_irq_gen: NUM_CH must be at least 1");
      if (CNT_W < 1)   $error("ts_irq_gen: CNT_W must be at least 1");
      if (TIME_W < 1)  $error("ts_irq_gen: TIME_W must be at least 1");
   end

   ts_irq_pkg::ch_flag_t ch_flag [NUM_CH];
   logic [FLAT_W-1:0]    cnt_flat;
   logic [TIME_W-1:0]    ms_cnt;
   logic                 due;
   logic                 fire;

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      ts_chan_cnt #(.CNT_W(CNT_W)) u_cnt (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .en_i   (acq_en_i),
         .clr_i  (fire),
         .stb_i  (wr_stb_i[g]),
         .thr_i  (cnt_thresh_i),
         .cnt_o  (cnt_flat[g*CNT_W +: CNT_W]),
         .flag_o (ch_flag[g])
      );
   end

   ts_ms_timer #(.TIME_W(TIME_W)) u_tmr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (acq_en_i),
      .clr_i  (fire),
      .tick_i (ms_tick_i),
      .thr_i  (time_thresh_i),
      .ms_o   (ms_cnt),
      .due_o  (due)
   );

   ts_irq_pulse #(.NUM_CH(NUM_CH)) u_pls (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (acq_en_i),
      .flags_i (ch_flag),
      .due_i   (due),
      .fire_o  (fire),
      .irq_o   (irq_o)
   );

endmodule

// File: rtl/ts_irq_gen_chk.sv
module ts_irq_gen_chk #(
   parameter int unsigned NUM_CH = 5,
   parameter int unsigned CNT_W  = 8,
   parameter int unsigned TIME_W = 32
) (
   input logic                    clk_i,
   input logic                    rst_ni,
   input logic                    acq_en_i,
   input logic                    ms_tick_i,
   input logic [CNT_W-1:0]        cnt_thresh_i,
   input logic [TIME_W-1:0]       time_thresh_i,
   input logic                    irq_o,
   input logic [NUM_CH*CNT_W-1:0] cnt_flat,
   input logic [TIME_W-1:0]       ms_cnt
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic any_above;
   logic any_nonzero;
   logic all_le_one;

   always_comb begin
      any_above   = 1'b0;
      any_nonzero = 1'b0;
      all_le_one  = 1'b1;
      for (int i = 0; i < NUM_CH; i++) begin
         if (cnt_flat[i*CNT_W +: CNT_W] > cnt_thresh_i) any_above = 1'b1;
         if (cnt_flat[i*CNT_W +: CNT_W] != '0)          any_nonzero = 1'b1;
         if (cnt_flat[i*CNT_W +: CNT_W] > CNT_W'(1))    all_le_one = 1'b0;
      end
   end

   // R7
   pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |=> !irq_o);

   // R8
   disabled_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !acq_en_i |=> !irq_o);

   // R6
   restart_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> (ms_cnt == '0) && all_le_one);

   // R2
   count_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (acq_en_i && !irq_o && any_above) |=> irq_o);

   // R4
   timeout_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (acq_en_i && !irq_o && any_nonzero && (ms_cnt >= time_thresh_i)) |=> irq_o);

   // R5
   timer_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (acq_en_i && !irq_o && !any_nonzero && ms_tick_i && (ms_cnt >= time_thresh_i))
      |=> (ms_cnt == $past(ms_cnt)));

   for (genvar g = 0; g < NUM_CH; g++) begin : g_sat
      // R9
      no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (acq_en_i && !irq_o && !any_above && !(any_nonzero && (ms_cnt >= time_thresh_i))
          && (cnt_flat[g*CNT_W +: CNT_W] == CNT_MAX))
         |=> (cnt_flat[g*CNT_W +: CNT_W] == CNT_MAX));
   end

endmodule

bind ts_irq_gen ts_irq_gen_chk #(
   .NUM_CH (NUM_CH),
   .CNT_W  (CNT_W),
   .TIME_W (TIME_W)
) u_chk (
   .clk_i         (clk_i),
   .rst_ni        (rst_ni),
   .acq_en_i      (acq_en_i),
   .ms_tick_i     (ms_tick_i),
   .cnt_thresh_i  (cnt_thresh_i),
   .time_thresh_i (time_thresh_i),
   .irq_o         (irq_o),
   .cnt_flat      (cnt_flat),
   .ms_cnt        (ms_cnt)
);

// File: tb/sim_ts_irq_gen.sv
module sim_ts_irq_gen;
   localparam int NCH  = 5;
   localparam int CW   = 8;
   localparam int TW   = 32;
   localparam int CMAX = 255;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          en = 1'b0;
   logic [NCH-1:0] stb = '0;
   logic          tick = 1'b0;
   logic [CW-1:0] cthr = '0;
   logic [TW-1:0] tthr = '0;
   logic          irq;

   always #5 clk = ~clk;

   ts_irq_gen #(.NUM_CH(NCH), .CNT_W(CW), .TIME_W(TW)) u0 (
      .clk_i(clk), .rst_ni(rst_n), .acq_en_i(en), .wr_stb_i(stb),
      .ms_tick_i(tick), .cnt_thresh_i(cthr), .time_thresh_i(tthr), .irq_o(irq)
   );

   int      n_cmp = 0;
   int      n_bad = 0;
   int      pulses = 0;
   string   tag = "R1";
   bit      done = 1'b0;

   // behavioural reference
   int      m_cnt [NCH];
   longint  m_ms;
   bit      m_irq;

   initial begin
      foreach (m_cnt[i]) m_cnt[i] = 0;
      m_ms = 0;
      m_irq = 1'b0;
   end

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n || !en) begin
         foreach (m_cnt[i]) m_cnt[i] = 0;
         m_ms  = 0;
         m_irq = 1'b0;
      end else begin
         bit hit_c, have, go;
         hit_c = 1'b0;
         have  = 1'b0;
         foreach (m_cnt[i]) begin
            if (m_cnt[i] > int'(cthr)) hit_c = 1'b1;
            if (m_cnt[i] > 0) have = 1'b1;
         end
         go = !m_irq && (hit_c || (have && (m_ms >= longint'(tthr))));
         foreach (m_cnt[i]) begin
            if (go) m_cnt[i] = stb[i] ? 1 : 0;
            else if (stb[i] && m_cnt[i] < CMAX) m_cnt[i] = m_cnt[i] + 1;
         end
         if (go) m_ms = 0;
         else if (tick && m_ms < longint'(tthr)) m_ms = m_ms + 1;
         m_irq = go;
      end
   end

   always @(negedge clk) begin
      if (!done) begin
         n_cmp++;
         if (irq !== m_irq) begin
            n_bad++;
            $display("FAIL %s irq_o actual=%b expected=%b at %0t", tag, irq, m_irq, $time);
         end
         if (irq === 1'b1) pulses++;
      end
   end

   task automatic step(int n = 1);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         #2;
      end
   endtask

   task automatic phase(string r);
      en = 1'b0;
      stb = '0;
      tick = 1'b0;
      step(2);
      tag = r;
      pulses = 0;
   endtask

   task automatic strobe(logic [NCH-1:0] m);
      stb = m;
      step(1);
      stb = '0;
   endtask

   task automatic ms(int n);
      for (int k = 0; k < n; k++) begin
         tick = 1'b1;
         step(1);
         tick = 1'b0;
         step(1);
      end
   endtask

   task automatic want_pulses(string r, int exp);
      n_cmp++;
      if (pulses != exp) begin
         n_bad++;
         $display("FAIL %s pulse count actual=%0d expected=%0d", r, pulses, exp);
      end
   endtask

   initial begin
      step(4);
      // R1: reset state
      n_cmp++;
      if (irq !== 1'b0) begin
         n_bad++;
         $display("FAIL R1 irq_o in reset actual=%b expected=0", irq);
      end
      rst_n = 1'b1;
      step(3);
      want_pulses("R1", 0);

      // R2: channel 2 exceeds threshold 3 on the fourth strobe
      phase("R2");
      cthr = 8'd3; tthr = 32'd1000; en = 1'b1;
      for (int k = 0; k < 4; k++) begin strobe(5'b00100); step(1); end
      step(5);
      want_pulses("R2", 1);

      // R3: all channels twice each, none above 2
      phase("R3");
      cthr = 8'd2; tthr = 32'd1000; en = 1'b1;
      strobe(5'b11111);
      strobe(5'b11111);
      step(6);
      want_pulses("R3", 0);

      // R4: one timestamp, then five ms ticks reach threshold 5
      phase("R4");
      cthr = 8'd255; tthr = 32'd5; en = 1'b1;
      strobe(5'b00001);
      ms(4);
      want_pulses("R4", 0);
      ms(1);
      step(3);
      want_pulses("R4", 1);

      // R5: timer stalls with no timestamps, later strobe fires
      phase("R5");
      cthr = 8'd255; tthr = 32'd3; en = 1'b1;
      ms(10);
      want_pulses("R5", 0);
      strobe(5'b01000);
      step(3);
      want_pulses("R5", 1);

      // R7: both conditions true together give one pulse
      phase("R7");
      cthr = 8'd0; tthr = 32'd0; en = 1'b1;
      step(3);
      strobe(5'b10000);
      step(5);
      want_pulses("R7", 1);

      // R6: back-to-back strobes across restart edges
      phase("R6");
      cthr = 8'd0; tthr = 32'd100; en = 1'b1;
      stb = 5'b00010;
      tick = 1'b1;
      step(6);
      stb = '0;
      tick = 1'b0;
      step(6);
      want_pulses("R6", 4);

      // R8: disabled activity ignored, old counts discarded
      phase("R8");
      cthr = 8'd1; tthr = 32'd1000; en = 1'b1;
      strobe(5'b00001);
      en = 1'b0;
      for (int k = 0; k < 5; k++) strobe(5'b00001);
      ms(3);
      en = 1'b1;
      strobe(5'b00001);
      step(5);
      want_pulses("R8", 0);

      // R9: saturation at 255 never exceeds threshold 255
      phase("R9");
      cthr = 8'd255; tthr = 32'hFFFF_FFFF; en = 1'b1;
      stb = 5'b10000;
      step(300);
      stb = '0;
      step(4);
      want_pulses("R9", 0);
      tthr = 32'd0;
      step(4);
      want_pulses("R9", 1);

      phase("R1");
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(10 * 20000);
      if (!done) begin
         done = 1'b1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog in %s actual=hung expected=finished", tag);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule